// File: doc/BRIEF.md
# Configuration Data Register Block with Counted Clock Bursts

This block is a small register file that sits behind a configuration-space and memory-space write port. It provides two fixed read-only capability header words, a status word that reflects live controller signals, a mode-control register, a programming-control register, and a data register that is up to 64 bits wide. A host loads a configuration image by writing it one word at a time. Each accepted data write places the word on `cfg_data` and sends a counted train of clock pulses on `cfg_clk` to a downstream configuration controller. The number of pulses per word comes from the clock-to-data ratio field in mode control.

The write port is a valid/ready stream. A write completes on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` stays low for the whole of a running pulse train. While `wr_valid` is high and `wr_ready` is low, the source must hold the address, data, byte enables and `wr_mem` unchanged. Reads use a separate combinational port. Status inputs and control outputs are plain level signals.

Address map (byte offsets; bits [1:0] of an address are ignored):

| Offset | Register |
|---|---|
| 0x200 | capability header |
| 0x204 | identification header |
| 0x21C | status |
| 0x220 | mode control |
| 0x224 | upper data word |
| 0x228 | lower data word |
| 0x22C | programming control |

Top module: `cfg_burst_regs`

## Requirements
- R1: A read of byte offset 0x200 returns 0x0001000B: bits [15:0] hold 0x000B, bits [19:16] hold 1, and the next-offset field [31:20] holds 0. A read of offset 0x204 returns 0x04401172: ID 0x1172, revision 0, and length 0x044 in bits [31:20].
- R2: After reset, mode control (0x220) and programming control (0x22C) read as 0, and all control outputs are low.
- R3: Status (0x21C) reads the controller inputs directly in bits [4:0]:
  - bit 0: ready
  - bit 1: error
  - bit 2: enable
  - bit 3: user mode
  - bit 4: config done
  - all other bits read 0.
- R4: A configuration-space write (`wr_mem`=0) to 0x220 updates mode control, with byte enables honoured per byte.
  - Byte 0 holds: bit 0 mode enable (`cfg_mode`), bit 1 clock select (`cfg_clk_sel`), bit 2 full-reconfiguration request (`cfg_full_reconfig`).
  - Byte 1 (bits [15:8]) holds the clock count N.
  - Unused bits read 0.
- R5: A configuration-space write to 0x22C with byte enable 0 set updates programming control: bit 0 is the begin-configuration bit (`cfg_begin`) and bit 1 is the start-transfer bit (`cfg_start_xfer`).
- R6: An accepted configuration-space write to 0x228 with all four byte enables set does two things.
  - It drives `cfg_data` to {upper word, written word}.
  - It emits exactly N pulses on `cfg_clk`. Each pulse is high for one cycle and is followed by one low cycle, and the first pulse is high in the cycle after acceptance.
- R7: When the clock count N is 0, a data write emits exactly one pulse.
- R8: A write to 0x228 or 0x224 whose byte enables are not all set has no effect: no pulse is emitted, and neither `cfg_data` nor the stored upper word changes.
- R9: A full-byte-enable write to 0x224 stores the upper 32 bits of the data, which become `cfg_data[63:32]` at the next data write. The stored word reads back at 0x224.
- R10: While mode enable is set, a memory-space write (`wr_mem`=1) to any address is treated as a data write. While mode enable is clear, a memory-space write changes nothing.
- R11: `wr_ready` is low while a pulse train runs, and `cfg_data` stays stable until the train ends. A write held off in this way is accepted in the cycle after the train ends, and its own train follows.
- R12: A read of any offset not listed in this brief returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write can be accepted; low during a pulse train |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte enables |
| wr_mem | input | 1 | 1 = memory-space write, 0 = configuration-space write |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| st_ready | input | 1 | Controller ready |
| st_error | input | 1 | Controller error |
| st_enable | input | 1 | Controller has enabled loading through this path |
| st_user_mode | input | 1 | Fabric in user mode |
| st_cfg_done | input | 1 | Configuration completed |
| cfg_data | output | DATA_W | Data word toward the controller |
| cfg_clk | output | 1 | Counted clock pulses toward the controller |
| cfg_mode | output | 1 | Mode enable bit |
| cfg_clk_sel | output | 1 | Clock select bit |
| cfg_full_reconfig | output | 1 | Full reconfiguration request bit |
| cfg_start_xfer | output | 1 | Start-transfer bit |
| cfg_begin | output | 1 | Begin-configuration bit |

## Verification
Data writes are tried with clock counts of 0, 1 and several larger values; a count of 0 and a count of 1 must both give one pulse. Byte enables are mixed between full and partial, which shows whether a partial data write is wrongly accepted. Memory-space writes go to random addresses with mode enable both set and clear, which shows whether the address is wrongly decoded or the mode is wrongly ignored. A write issued back-to-back behind a long train shows whether back-pressure holds, whether `cfg_data` stays stable, and whether the held write starts its own full train.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int OFS_CAP_HDR = 'h200;
  localparam int OFS_ID_HDR  = 'h204;
  localparam int OFS_STATUS  = 'h21C;
  localparam int OFS_MODE    = 'h220;
  localparam int OFS_DATA_HI = 'h224;
  localparam int OFS_DATA_LO = 'h228;
  localparam int OFS_PROG    = 'h22C;

  localparam logic [31:0] CAP_HDR_VAL = {12'h000, 4'h1, 16'h000B};
  localparam logic [31:0] ID_HDR_VAL  = {12'h044, 4'h0, 16'h1172};

  typedef struct packed {
    logic full_reconfig;
    logic clk_sel;
    logic mode_en;
  } mode_bits_t;

  typedef struct packed {
    logic start_xfer;
    logic begin_cfg;
  } prog_bits_t;
endpackage

// File: rtl/cbr_burst.sv
module cbr_burst #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] launch_cnt,
  output logic             pulse,
  output logic             busy
);
  logic [CNT_W-1:0] remain_q;
  logic             pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      pulse_q  <= 1'b0;
    end else if (launch) begin
      remain_q <= (launch_cnt == '0) ? CNT_W'(1) : launch_cnt;
      pulse_q  <= 1'b1;
    end else if (pulse_q) begin
      pulse_q  <= 1'b0;
      remain_q <= remain_q - 1'b1;
    end else if (remain_q != '0) begin
      pulse_q  <= 1'b1;
    end
  end

  assign pulse = pulse_q;
  assign busy  = (remain_q != '0);

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R6
  AST_FIRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> pulse_q); // R6
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy); // R11
endmodule

// File: rtl/cbr_regfile.sv
module cbr_regfile
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  input  logic              wr_mem,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [4:0]        status,
  output logic              launch,
  output logic [CNT_W-1:0]  launch_cnt,
  output logic [DATA_W-1:0] cfg_data,
  output mode_bits_t        mode_o,
  output prog_bits_t        prog_o
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] I_CAP  = IW'(OFS_CAP_HDR >> 2);
  localparam logic [IW-1:0] I_ID   = IW'(OFS_ID_HDR >> 2);
  localparam logic [IW-1:0] I_STAT = IW'(OFS_STATUS >> 2);
  localparam logic [IW-1:0] I_MODE = IW'(OFS_MODE >> 2);
  localparam logic [IW-1:0] I_HI   = IW'(OFS_DATA_HI >> 2);
  localparam logic [IW-1:0] I_LO   = IW'(OFS_DATA_LO >> 2);
  localparam logic [IW-1:0] I_PROG = IW'(OFS_PROG >> 2);
  localparam bit WIDE = (DATA_W == 64);

  logic [IW-1:0] w_idx, r_idx;
  logic unused_addr_lsbs;
  assign w_idx = wr_addr[ADDR_W-1:2];
  assign r_idx = rd_addr[ADDR_W-1:2];
  assign unused_addr_lsbs = ^{wr_addr[1:0], rd_addr[1:0]};

  logic full_be, cfg_wr, data_wr;
  assign full_be = &wr_be;
  assign cfg_wr  = accept && !wr_mem;

  mode_bits_t       mode_q;
  logic [CNT_W-1:0] cnt_q;
  prog_bits_t       prog_q;
  logic [31:0]      upper;

  assign data_wr = accept && full_be &&
                   ((wr_mem && mode_q.mode_en) || (!wr_mem && w_idx == I_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnt_q  <= '0;
      prog_q <= '0;
    end else if (cfg_wr) begin
      if (w_idx == I_MODE) begin
        if (wr_be[0]) mode_q <= mode_bits_t'(wr_data[2:0]);
        if (wr_be[1]) cnt_q  <= wr_data[8 +: CNT_W];
      end
      if (w_idx == I_PROG && wr_be[0]) prog_q <= prog_bits_t'(wr_data[1:0]);
    end
  end

  generate
    if (WIDE) begin : g_wide
      logic [31:0] upper_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upper_q <= '0;
        else if (cfg_wr && full_be && w_idx == I_HI) upper_q <= wr_data;
      end
      assign upper = upper_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_data <= '0;
        else if (data_wr) cfg_data <= {upper_q, wr_data};
      end
    end else begin : g_narrow
      assign upper = '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_data <= '0;
        else if (data_wr) cfg_data <= DATA_W'(wr_data);
      end
    end
  endgenerate

  logic [31:0] mode_rd;
  always_comb begin
    mode_rd = '0;
    mode_rd[2:0] = mode_q;
    mode_rd[8 +: CNT_W] = cnt_q;
  end

  always_comb begin
    case (r_idx)
      I_CAP:   rd_data = CAP_HDR_VAL;
      I_ID:    rd_data = ID_HDR_VAL;
      I_STAT:  rd_data = {27'b0, status};
      I_MODE:  rd_data = mode_rd;
      I_HI:    rd_data = upper;
      I_PROG:  rd_data = {30'b0, prog_q};
      default: rd_data = '0;
    endcase
  end

  assign launch     = data_wr;
  assign launch_cnt = cnt_q;
  assign mode_o     = mode_q;
  assign prog_o     = prog_q;

  AST_MEM_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_mem && !mode_q.mode_en) |=> $stable(cfg_data)); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(mode_q) && $stable(prog_q))); // R4
endmodule

// File: rtl/cfg_burst_regs.sv
module cfg_burst_regs
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  input  logic              wr_mem,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              st_ready,
  input  logic              st_error,
  input  logic              st_enable,
  input  logic              st_user_mode,
  input  logic              st_cfg_done,
  output logic [DATA_W-1:0] cfg_data,
  output logic              cfg_clk,
  output logic              cfg_mode,
  output logic              cfg_clk_sel,
  output logic              cfg_full_reconfig,
  output logic              cfg_start_xfer,
  output logic              cfg_begin
);
  logic             busy, accept, launch;
  logic [CNT_W-1:0] launch_cnt;
  mode_bits_t       mode_s;
  prog_bits_t       prog_s;

  assign wr_ready = !busy;
  assign accept   = wr_valid && !busy;

  cbr_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .wr_mem     (wr_mem),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .status     ({st_cfg_done, st_user_mode, st_enable, st_error, st_ready}),
    .launch     (launch),
    .launch_cnt (launch_cnt),
    .cfg_data   (cfg_data),
    .mode_o     (mode_s),
    .prog_o     (prog_s)
  );

  cbr_burst #(.CNT_W(CNT_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .launch_cnt (launch_cnt),
    .pulse      (cfg_clk),
    .busy       (busy)
  );

  assign cfg_mode          = mode_s.mode_en;
  assign cfg_clk_sel       = mode_s.clk_sel;
  assign cfg_full_reconfig = mode_s.full_reconfig;
  assign cfg_start_xfer    = prog_s.start_xfer;
  assign cfg_begin         = prog_s.begin_cfg;

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && $past(!wr_ready)) |-> $stable(cfg_data)); // R11
  AST_PARTIAL_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_be != 4'hF) |=> !cfg_clk); // R8
endmodule

// File: tb/test_cfg_burst_regs.sv
module test_cfg_burst_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic wr_valid = 0, wr_ready, wr_mem = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [3:0]  wr_be = 0;
  logic [4:0]  st = 0;
  logic [63:0] cfg_data;
  logic cfg_clk, cfg_mode, cfg_clk_sel, cfg_full_reconfig, cfg_start_xfer, cfg_begin;

  cfg_burst_regs i_cfg_burst_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_mem(wr_mem),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .st_ready(st[0]), .st_error(st[1]), .st_enable(st[2]),
    .st_user_mode(st[3]), .st_cfg_done(st[4]),
    .cfg_data(cfg_data), .cfg_clk(cfg_clk), .cfg_mode(cfg_mode),
    .cfg_clk_sel(cfg_clk_sel), .cfg_full_reconfig(cfg_full_reconfig),
    .cfg_start_xfer(cfg_start_xfer), .cfg_begin(cfg_begin));

  int checks = 0, failures = 0, pulses = 0;
  logic [2:0]  m_bits = 0;
  logic [7:0]  m_cnt = 0;
  logic [1:0]  m_prog = 0;
  logic [31:0] m_upper = 0;
  logic [63:0] m_data = 0;
  int exp_pulses = 0;

  always @(negedge clk) if (cfg_clk) pulses++;

  function automatic int pulses_for(input logic [7:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  function automatic logic [31:0] mode_word();
    return {16'b0, m_cnt, 5'b0, m_bits};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); rd_addr = a; #1;
    check(req, rd_data, exp);
  endtask

  // model update for one accepted write, then issue it
  task automatic model(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be, input logic mem);
    exp_pulses = 0;
    if (mem) begin
      if (m_bits[0] && be == 4'hF) begin
        m_data = {m_upper, d}; exp_pulses = pulses_for(m_cnt);
      end
    end else begin
      case (a[11:2])
        10'h088: begin if (be[0]) m_bits = d[2:0]; if (be[1]) m_cnt = d[15:8]; end
        10'h089: if (be == 4'hF) m_upper = d;
        10'h08A: if (be == 4'hF) begin m_data = {m_upper, d}; exp_pulses = pulses_for(m_cnt); end
        10'h08B: if (be[0]) m_prog = d[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic do_wr(input string req, input logic [11:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic mem);
    model(a, d, be, mem);
    @(negedge clk);
    pulses = 0;
    wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be; wr_mem = mem;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
    while (!wr_ready) @(negedge clk);
    check(req, 64'(pulses), 64'(exp_pulses));
    check(req, cfg_data, m_data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    rd_check("R2", 12'h220, 32'h0);
    rd_check("R2", 12'h22C, 32'h0);
    check("R2", {cfg_mode, cfg_clk_sel, cfg_full_reconfig, cfg_start_xfer, cfg_begin}, 0);
    check("R2", cfg_data, 0);
    // R1 headers
    rd_check("R1", 12'h200, 32'h0001000B);
    rd_check("R1", 12'h204, 32'h04401172);
    rd_check("R1", 12'h203, 32'h0001000B);
    // R12 unmapped
    rd_check("R12", 12'h208, 32'h0);
    rd_check("R12", 12'h230, 32'h0);
    // R3 status
    for (int i = 0; i < 4; i++) begin
      st = 5'($urandom);
      rd_check("R3", 12'h21C, {27'b0, st});
    end
    // R7 count 0 gives one pulse
    do_wr("R7", 12'h228, 32'hCAFE0001, 4'hF, 0);
    // R4 mode write with clock count 1
    do_wr("R4", 12'h220, 32'h0000_0106, 4'h3, 0);
    rd_check("R4", 12'h220, mode_word());
    check("R4", {cfg_full_reconfig, cfg_clk_sel, cfg_mode}, 3'b110);
    do_wr("R7", 12'h228, 32'h11112222, 4'hF, 0);
    // R5 programming control
    do_wr("R5", 12'h22C, 32'h3, 4'h1, 0);
    check("R5", {cfg_start_xfer, cfg_begin}, 2'b11);
    do_wr("R5", 12'h22C, 32'h0, 4'h2, 0);
    check("R5", {cfg_start_xfer, cfg_begin}, 2'b11);
    // R9 upper word
    do_wr("R9", 12'h224, 32'hA5A5_5A5A, 4'hF, 0);
    rd_check("R9", 12'h224, 32'hA5A5_5A5A);
    do_wr("R9", 12'h224, 32'hDEAD_BEEF, 4'h7, 0);
    rd_check("R8", 12'h224, 32'hA5A5_5A5A);
    // R8 partial data write
    do_wr("R8", 12'h228, 32'h0BAD0BAD, 4'hE, 0);
    // R6 count 5
    do_wr("R4", 12'h220, 32'h0000_0501, 4'h3, 0);
    do_wr("R6", 12'h228, 32'h12345678, 4'hF, 0);
    // R10 memory writes with mode set then clear
    do_wr("R10", 12'h0F0, 32'h87654321, 4'hF, 1);
    do_wr("R10", 12'h220, 32'h0, 4'hF, 1);
    rd_check("R10", 12'h220, mode_word());
    do_wr("R4", 12'h220, 32'h0000_0300, 4'h3, 0);
    do_wr("R10", 12'h228, 32'hFFFF0000, 4'hF, 1);
    // R11 back-pressure with count 3
    @(negedge clk);
    pulses = 0;
    wr_valid = 1; wr_addr = 12'h228; wr_data = 32'hAAAA0001; wr_be = 4'hF; wr_mem = 0;
    @(negedge clk);
    wr_data = 32'hBBBB0002;
    check("R11", 64'(wr_ready), 0);
    check("R11", cfg_data, {m_upper, 32'hAAAA0001});
    @(negedge clk); @(negedge clk);
    check("R11", cfg_data, {m_upper, 32'hAAAA0001});
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
    check("R11", 64'(cfg_clk), 1);
    while (!wr_ready) @(negedge clk);
    m_data = {m_upper, 32'hBBBB0002};
    check("R11", 64'(pulses), 6);
    check("R11", cfg_data, m_data);
    // random mix
    for (int i = 0; i < 80; i++) begin
      int op;
      logic [3:0] be;
      logic [31:0] d;
      op = int'($urandom_range(0, 5));
      be = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      d  = $urandom;
      case (op)
        0: do_wr("R4", 12'h220, {16'b0, 8'($urandom_range(0, 6)), 7'b0, 1'($urandom)}, be, 0);
        1: do_wr("R9", 12'h224, d, be, 0);
        2, 3: do_wr("R6", 12'h228, d, be, 0);
        4: do_wr("R10", 12'h200 + 12'($urandom_range(0, 255)), d, be, 1);
        default: do_wr("R5", 12'h22C, d, be, 0);
      endcase
      if (i % 10 == 0) begin
        rd_check("R4", 12'h220, mode_word());
        rd_check("R5", 12'h22C, {30'b0, m_prog});
        rd_check("R9", 12'h224, m_upper);
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule